// File: doc/BRIEF.md
# PHY Bring-up and Autonegotiation Sequencer

This block is a controller state machine that sits above an MDIO management master and brings a 10/100 Ethernet PHY into service. After a start pulse it resets the PHY and waits for the reset bit to clear. It then captures a vendor status register and programs the vendor interrupt mask. It reads the PHY's ability bits and builds an advertisement word from them. Finally it restarts autonegotiation and polls for completion. If the PHY reports a remote fault while it waits, it forces a renegotiation.

Each register access goes out as one request, held on the `req_*` outputs until the MDIO master returns `req_done`. The waits between polls are paced by an external `tick` pulse, nominally every half second. The block ignores ticks that arrive outside a wait. At the end it gives a one-cycle `done` with a two-bit result code. On success it sets the speed and duplex outputs from the vendor status word captured right after reset.

Top module: `phy_bringup_seq`

## Requirements
- R1: While reset is held, and afterwards until the first start, the block drives the following outputs low: `busy`, `req_valid`, `done`, `speed_100`, `full_duplex` and `err_code`.
- R2: When `start` arrives while the block is idle, the first request is a write of 0x8000 (bit 15, the reset bit) to register 0.
- R3: Register 0 is then read. If bit 15 is clear, the reset phase ends. If bit 15 is set, the block waits for a `tick` and reads again. When the sixth read still shows bit 15 set, the block ends with `err_code` 1 and issues no further request.
- R4: Once reset has cleared, register 18 is read exactly once and its value is kept. Next, register 19 is written with 0xFCC0.
- R5: Register 1 is read. Register 4 is then written with 0x0001 OR'd with the ability bits of that read, moved from bits 15,14,13,12,11 to bits 9,8,7,6,5 in that order.
- R6: Register 0 is then written with 0x1200, which sets the enable bit (bit 12) and the restart bit (bit 9).
- R7: Completion is polled by reading register 1 and testing bit 5, with a `tick` wait before every read after the first. If 20 reads pass without bit 5 set and without bit 4 set on the last read, the block ends with `err_code` 2.
- R8: A poll read that has bit 4 (remote fault) set and ends neither by completion nor by reaching the limit is followed, after the tick, by a write of 0x3300 to register 0 and then the next read.
- R9: If the final poll read has bit 4 set, the block ends with `err_code` 3, even when bit 5 is also set.
- R10: On success `err_code` is 0, `speed_100` takes bit 7 of the kept register-18 value and `full_duplex` takes bit 6. These two outputs change only in the cycle where `done` is high for a success.
- R11: `done` is high for exactly one cycle, and in that cycle `busy` is low. `err_code` holds its value until the next `done`. A `start` that arrives while `busy` is high has no effect.
- R12: The fields of a request stay stable while `req_valid` is high. The access completes in the cycle where `req_done` is high. Read data is taken from `req_rdata` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the bring-up sequence (honoured only when idle) |
| tick | input | 1 | Poll-interval pulse |
| req_valid | output | 1 | A management access is requested |
| req_write | output | 1 | 1 = write, 0 = read |
| req_reg | output | 5 | PHY register number |
| req_wdata | output | 16 | Write data |
| req_done | input | 1 | Access complete |
| req_rdata | input | 16 | Read data, valid with req_done |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err_code | output | 2 | 0 ok, 1 reset timeout, 2 negotiation timeout, 3 remote fault |
| speed_100 | output | 1 | 1 = 100 Mb/s result |
| full_duplex | output | 1 | 1 = full duplex result |

## Verification
A wrong state shows up at the next request, as a wrong register number, direction or write value. That is at most one transaction plus one tick after the fault. A poll counter that is off by one shows as one read of register 0 or register 1 too many or too few, just before `done`. A corrupted copy of the vendor status stays hidden until `done`, where `speed_100` or `full_duplex` disagrees with bits 7 and 6 of the register-18 read. So every scenario compares the full ordered list of accesses as well as the end result.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    // sequencer states
    typedef enum logic [3:0] {
        S_IDLE,
        S_RST_WR,
        S_RST_RD,
        S_RST_WAIT,
        S_VEND_RD,
        S_MASK_WR,
        S_CAP_RD,
        S_ADV_WR,
        S_AN_WR,
        S_AN_RD,
        S_AN_WAIT,
        S_RF_WR
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_RST_TMO = 2'd1,
        ERR_AN_TMO  = 2'd2,
        ERR_RFAULT  = 2'd3
    } seq_err_e;

    // control register bit positions
    localparam int CTL_RESET   = 15;
    localparam int CTL_SPEED   = 13;
    localparam int CTL_AN_EN   = 12;
    localparam int CTL_AN_RST  = 9;
    localparam int CTL_DUPLEX  = 8;

    // status register bit positions
    localparam int STS_AN_DONE = 5;
    localparam int STS_RFAULT  = 4;
    localparam int STS_ABIL_LO = 11;

    // advertisement layout
    localparam int ADV_ABIL_LO = 5;
    localparam int ABIL_N      = 5;

endpackage

// File: rtl/phy_adv_map.sv
module phy_adv_map #(
    parameter int ABIL_W = phy_seq_pkg::ABIL_N,
    parameter int ADV_LO = phy_seq_pkg::ADV_ABIL_LO
) (
    input  logic [ABIL_W-1:0] abil,
    output logic [15:0]       adv
);
    localparam int ADV_HI = ADV_LO + ABIL_W;

    // selector field: IEEE 802.3 CSMA/CD
    assign adv[0] = 1'b1;
    assign adv[ADV_LO-1:1] = '0;
    assign adv[15:ADV_HI] = '0;

    for (genvar i = 0; i < ABIL_W; i++) begin : g_abil
        assign adv[ADV_LO+i] = abil[i];
    end
endmodule

// File: rtl/phy_poll_ctr.sv
module phy_poll_ctr #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // the read now completing is the final one allowed
    assign last = (cnt_q == limit - 1'b1);
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq #(
    parameter int          RST_POLLS    = 6,
    parameter int          AN_POLLS     = 20,
    parameter int          REG_CTRL     = 0,
    parameter int          REG_STAT     = 1,
    parameter int          REG_ADV      = 4,
    parameter int          REG_VEND     = 18,
    parameter int          REG_MASK     = 19,
    parameter logic [15:0] MASK_VALUE   = 16'hFCC0,
    parameter int          VEND_SPD_BIT = 7,
    parameter int          VEND_DPX_BIT = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        tick,
    output logic        req_valid,
    output logic        req_write,
    output logic [4:0]  req_reg,
    output logic [15:0] req_wdata,
    input  logic        req_done,
    input  logic [15:0] req_rdata,
    output logic        busy,
    output logic        done,
    output logic [1:0]  err_code,
    output logic        speed_100,
    output logic        full_duplex
);
    import phy_seq_pkg::*;

    localparam int MAXP  = (RST_POLLS > AN_POLLS) ? RST_POLLS : AN_POLLS;
    localparam int CNT_W = $clog2(MAXP + 1);

    localparam logic [15:0] W_RESET = 16'h1 << CTL_RESET;
    localparam logic [15:0] W_AN    = (16'h1 << CTL_AN_EN) | (16'h1 << CTL_AN_RST);
    localparam logic [15:0] W_AN_RF = W_AN | (16'h1 << CTL_SPEED) | (16'h1 << CTL_DUPLEX);

    typedef struct packed {
        seq_state_e  state;
        logic        v_spd;
        logic        v_dpx;
        logic [15:0] adv;
        logic        rf;
        logic        done;
        seq_err_e    err;
        logic        spd;
        logic        dpx;
    } seq_regs_t;

    localparam seq_regs_t REGS_RST = '{
        state: S_IDLE, v_spd: 1'b0, v_dpx: 1'b0, adv: 16'h0, rf: 1'b0,
        done: 1'b0, err: ERR_NONE, spd: 1'b0, dpx: 1'b0
    };

    seq_regs_t d, q;

    logic [15:0]      adv_w;
    logic             pc_clr, pc_inc, pc_last;
    logic [CNT_W-1:0] poll_lim;
    logic             unused_rdata;

    phy_adv_map u_map (
        .abil (req_rdata[STS_ABIL_LO +: ABIL_N]),
        .adv  (adv_w)
    );

    assign poll_lim = (q.state == S_RST_RD || q.state == S_RST_WAIT)
                    ? CNT_W'(RST_POLLS) : CNT_W'(AN_POLLS);

    phy_poll_ctr #(.W(CNT_W)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pc_clr),
        .inc   (pc_inc),
        .limit (poll_lim),
        .last  (pc_last)
    );

    assign unused_rdata = ^req_rdata;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        pc_clr = 1'b0;
        pc_inc = 1'b0;
        case (q.state)
            S_IDLE: if (start) begin
                d.state = S_RST_WR;
                pc_clr  = 1'b1;
            end
            S_RST_WR:  if (req_done) d.state = S_RST_RD;
            S_RST_RD: if (req_done) begin
                pc_inc = 1'b1;
                if (!req_rdata[CTL_RESET]) begin
                    d.state = S_VEND_RD;
                end else if (pc_last) begin
                    d.state = S_IDLE;
                    d.done  = 1'b1;
                    d.err   = ERR_RST_TMO;
                end else begin
                    d.state = S_RST_WAIT;
                end
            end
            S_RST_WAIT: if (tick) d.state = S_RST_RD;
            S_VEND_RD: if (req_done) begin
                d.v_spd = req_rdata[VEND_SPD_BIT];
                d.v_dpx = req_rdata[VEND_DPX_BIT];
                d.state = S_MASK_WR;
            end
            S_MASK_WR: if (req_done) d.state = S_CAP_RD;
            S_CAP_RD: if (req_done) begin
                d.adv   = adv_w;
                d.state = S_ADV_WR;
            end
            S_ADV_WR: if (req_done) d.state = S_AN_WR;
            S_AN_WR: if (req_done) begin
                d.state = S_AN_RD;
                pc_clr  = 1'b1;
            end
            S_AN_RD: if (req_done) begin
                pc_inc = 1'b1;
                d.rf   = req_rdata[STS_RFAULT];
                if (req_rdata[STS_AN_DONE] || pc_last) begin
                    d.state = S_IDLE;
                    d.done  = 1'b1;
                    if (req_rdata[STS_RFAULT])       d.err = ERR_RFAULT;
                    else if (!req_rdata[STS_AN_DONE]) d.err = ERR_AN_TMO;
                    else begin
                        d.err = ERR_NONE;
                        d.spd = q.v_spd;
                        d.dpx = q.v_dpx;
                    end
                end else begin
                    d.state = S_AN_WAIT;
                end
            end
            S_AN_WAIT: if (tick) d.state = q.rf ? S_RF_WR : S_AN_RD;
            S_RF_WR:   if (req_done) d.state = S_AN_RD;
            default:   d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= REGS_RST;
        else        q <= d;
    end

    // request decode from the registered state
    always_comb begin
        req_valid = 1'b1;
        req_write = 1'b0;
        req_reg   = 5'd0;
        req_wdata = 16'h0;
        case (q.state)
            S_RST_WR:  begin req_write = 1'b1; req_reg = 5'(REG_CTRL); req_wdata = W_RESET;    end
            S_RST_RD:  begin                   req_reg = 5'(REG_CTRL);                         end
            S_VEND_RD: begin                   req_reg = 5'(REG_VEND);                         end
            S_MASK_WR: begin req_write = 1'b1; req_reg = 5'(REG_MASK); req_wdata = MASK_VALUE; end
            S_CAP_RD:  begin                   req_reg = 5'(REG_STAT);                         end
            S_ADV_WR:  begin req_write = 1'b1; req_reg = 5'(REG_ADV);  req_wdata = q.adv;      end
            S_AN_WR:   begin req_write = 1'b1; req_reg = 5'(REG_CTRL); req_wdata = W_AN;       end
            S_AN_RD:   begin                   req_reg = 5'(REG_STAT);                         end
            S_RF_WR:   begin req_write = 1'b1; req_reg = 5'(REG_CTRL); req_wdata = W_AN_RF;    end
            default:   req_valid = 1'b0;
        endcase
    end

    assign busy        = (q.state != S_IDLE);
    assign done        = q.done;
    assign err_code    = q.err;
    assign speed_100   = q.spd;
    assign full_duplex = q.dpx;
endmodule

// File: rtl/phy_bringup_chk.sv
module phy_bringup_chk #(
    parameter int          REG_CTRL   = 0,
    parameter int          REG_ADV    = 4,
    parameter int          REG_MASK   = 19,
    parameter logic [15:0] MASK_VALUE = 16'hFCC0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [4:0]  req_reg,
    input logic [15:0] req_wdata,
    input logic        req_done,
    input logic        busy,
    input logic        done,
    input logic [1:0]  err_code,
    input logic        speed_100,
    input logic        full_duplex
);
    assert_first_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (req_valid && req_write && req_reg == 5'(REG_CTRL) && req_wdata == 16'h8000));

    assert_mask_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_reg == 5'(REG_MASK)) |-> (req_wdata == MASK_VALUE));

    assert_adv_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_reg == 5'(REG_ADV))
            |-> (req_wdata[0] && req_wdata[4:1] == 4'h0 && req_wdata[15:10] == 6'h0));

    // R6 and R8: only three control words are ever written
    assert_ctrl_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_reg == 5'(REG_CTRL))
            |-> (req_wdata == 16'h8000 || req_wdata == 16'h1200 || req_wdata == 16'h3300));

    assert_link_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(speed_100) && $stable(full_duplex)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !req_valid));

    assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(err_code));

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_done)
            |=> (req_valid && $stable(req_write) && $stable(req_reg) && $stable(req_wdata)));
endmodule

bind phy_bringup_seq phy_bringup_chk #(
    .REG_CTRL   (REG_CTRL),
    .REG_ADV    (REG_ADV),
    .REG_MASK   (REG_MASK),
    .MASK_VALUE (MASK_VALUE)
) u_chk (.*);

// File: tb/sim_phy_bringup_seq.sv
module sim_phy_bringup_seq;
    localparam int LAT      = 3;
    localparam int TICK_PER = 37;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        tick = 1'b0;
    logic        req_valid, req_write;
    logic [4:0]  req_reg;
    logic [15:0] req_wdata;
    logic        req_done = 1'b0;
    logic [15:0] req_rdata = 16'h0;
    logic        busy, done, speed_100, full_duplex;
    logic [1:0]  err_code;

    always #2 clk = ~clk;

    phy_bringup_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
        .req_valid(req_valid), .req_write(req_write), .req_reg(req_reg),
        .req_wdata(req_wdata), .req_done(req_done), .req_rdata(req_rdata),
        .busy(busy), .done(done), .err_code(err_code),
        .speed_100(speed_100), .full_duplex(full_duplex)
    );

    int errors = 0;
    int checks = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
        end
    endtask

    // scenario description
    int          sc_rst_busy;
    logic [15:0] sc_vend, sc_caps;
    int          sc_cmp_at;
    logic [31:0] sc_rf;
    int          n_r0, n_r1;

    // expected accesses {write, reg, data} with requirement tags
    logic [21:0] exp_q[$];
    string       tag_q[$];
    int          exp_err;
    string       done_tag;
    bit          exp_spd = 1'b0, exp_dpx = 1'b0;
    bit          expect_done = 1'b0, got_done = 1'b0;
    int          lat = 0;
    logic [21:0] cur;

    function automatic logic [15:0] poll_status(input int p);
        logic [15:0] s;
        s = sc_caps;
        if (sc_cmp_at != 0 && p >= sc_cmp_at) s = s | 16'h0020;
        if (sc_rf[p]) s = s | 16'h0010;
        return s;
    endfunction

    function automatic logic [15:0] adv_of(input logic [15:0] c);
        logic [15:0] a;
        a = 16'h0001;
        if (c[15]) a = a | 16'h0200;
        if (c[14]) a = a | 16'h0100;
        if (c[13]) a = a | 16'h0080;
        if (c[12]) a = a | 16'h0040;
        if (c[11]) a = a | 16'h0020;
        return a;
    endfunction

    task automatic push(input bit wr, input int rg, input logic [15:0] dat, input string tg);
        exp_q.push_back({wr, 5'(rg), dat});
        tag_q.push_back(tg);
    endtask

    task automatic build();
        bit          rst_ok;
        logic [15:0] fin;
        exp_q.delete();
        tag_q.delete();
        rst_ok = 1'b0;
        fin = 16'h0;
        push(1, 0, 16'h8000, "R2");
        for (int i = 1; i <= 6; i++) begin
            push(0, 0, 16'h0, "R3");
            if (i > sc_rst_busy) begin rst_ok = 1'b1; break; end
        end
        if (!rst_ok) begin
            exp_err = 1; done_tag = "R3";
            return;
        end
        push(0, 18, 16'h0, "R4");
        push(1, 19, 16'hFCC0, "R4");
        push(0, 1, 16'h0, "R5");
        push(1, 4, adv_of(sc_caps), "R5");
        push(1, 0, 16'h1200, "R6");
        for (int p = 1; p <= 20; p++) begin
            logic [15:0] s;
            s = poll_status(p);
            push(0, 1, 16'h0, "R7");
            if (s[5] || p == 20) begin fin = s; break; end
            if (s[4]) push(1, 0, 16'h3300, "R8");
        end
        if (fin[4])      begin exp_err = 3; done_tag = "R9";  end
        else if (!fin[5]) begin exp_err = 2; done_tag = "R7";  end
        else begin
            exp_err = 0; done_tag = "R10";
            exp_spd = sc_vend[7];
            exp_dpx = sc_vend[6];
        end
    endtask

    // poll-interval pulses, free running
    int tcnt = 0;
    always @(negedge clk) begin
        tcnt++;
        tick <= (tcnt % TICK_PER == 0);
    end

    // management master model and per-cycle comparison
    always @(negedge clk) begin
        req_done = 1'b0;
        if (!rst_n) begin
            lat = 0;
        end else begin
            if (expect_done) begin
                chk(done === 1'b1, done_tag, 32'(done), 32'd1);
                chk(err_code == 2'(exp_err), done_tag, 32'(err_code), 32'(exp_err));
                chk(speed_100 == exp_spd, "R10", 32'(speed_100), 32'(exp_spd));
                chk(full_duplex == exp_dpx, "R10", 32'(full_duplex), 32'(exp_dpx));
                chk(!busy, "R11", 32'(busy), 32'd0);
                expect_done = 1'b0;
                got_done = 1'b1;
            end else if (done) begin
                chk(1'b0, "R11", 32'(done), 32'd0);
            end
            if (req_valid) begin
                if (lat == 0) begin
                    cur = {req_write, req_reg, req_wdata};
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R11", 32'(cur), 32'd0);
                    end else begin
                        chk(req_write == exp_q[0][21] && req_reg == exp_q[0][20:16] &&
                            (!exp_q[0][21] || req_wdata == exp_q[0][15:0]),
                            tag_q[0], 32'(cur), 32'(exp_q[0]));
                    end
                end else begin
                    chk(cur == {req_write, req_reg, req_wdata}, "R12",
                        32'({req_write, req_reg, req_wdata}), 32'(cur));
                end
                if (lat == LAT) begin
                    req_done = 1'b1;
                    req_rdata = 16'h0;
                    if (!req_write && req_reg == 5'd0) begin
                        n_r0++;
                        req_rdata = (n_r0 <= sc_rst_busy) ? 16'h8000 : 16'h0000;
                    end else if (!req_write && req_reg == 5'd1) begin
                        n_r1++;
                        req_rdata = (n_r1 == 1) ? sc_caps : poll_status(n_r1 - 1);
                    end else if (!req_write && req_reg == 5'd18) begin
                        req_rdata = sc_vend;
                    end
                    if (exp_q.size() > 0) begin
                        void'(exp_q.pop_front());
                        void'(tag_q.pop_front());
                        if (exp_q.size() == 0) expect_done = 1'b1;
                    end
                    lat = 0;
                end else begin
                    lat++;
                end
            end
        end
    end

    task automatic run(input int rb, input logic [15:0] vend, input logic [15:0] caps,
                       input int cmp_at, input logic [31:0] rf, input bit dbl_start);
        int n;
        sc_rst_busy = rb; sc_vend = vend; sc_caps = caps;
        sc_cmp_at = cmp_at; sc_rf = rf;
        n_r0 = 0; n_r1 = 0;
        build();
        got_done = 1'b0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (dbl_start) begin
            // R11: a second start mid-sequence must not disturb the access order
            repeat (10) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        n = 0;
        while (!got_done && n < 6000) begin
            @(negedge clk);
            n++;
        end
        if (!got_done) chk(1'b0, "R11", 32'd0, 32'd1);
        chk(exp_q.size() == 0, done_tag, 32'(exp_q.size()), 32'd0);
        repeat (3) @(negedge clk);
        chk(!busy && !req_valid, "R11", 32'({busy, req_valid}), 32'd0);
        chk(err_code == 2'(exp_err), "R11", 32'(err_code), 32'(exp_err));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(!busy && !req_valid && !done && !speed_100 && !full_duplex && err_code == 2'd0,
            "R1", 32'({busy, req_valid, done, speed_100, full_duplex, err_code}), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !req_valid && !done && !speed_100 && !full_duplex && err_code == 2'd0,
            "R1", 32'({busy, req_valid, done, speed_100, full_duplex, err_code}), 32'd0);

        // success, 100 full, three reset reads, mid-run start ignored
        run(2, 16'h00C0, 16'h7800, 3, 32'h0, 1'b1);
        // reset never clears: six reads then timeout
        run(6, 16'h0000, 16'h7800, 1, 32'h0, 1'b0);
        // no completion, faults at polls 2 and 5, last poll clean
        run(0, 16'h0080, 16'h8000, 0, 32'h0000_0024, 1'b0);
        // reset clears on the sixth read; complete together with fault
        run(5, 16'h0000, 16'h1800, 4, 32'h0000_0014, 1'b0);
        // success, 10 full, all abilities, first poll complete
        run(0, 16'h0040, 16'hF800, 1, 32'h0, 1'b0);
        // fault on the final poll outranks the timeout
        run(1, 16'h00C0, 16'h4000, 0, 32'h0018_0000, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule